// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Controller

This block connects a synchronous host request port to a 64K x 4 dynamic memory whose sixteen address bits reach the part over eight shared pins. A host places a command, an address, write data and a write mask on its port and raises `req_i` while `busy_o` is low. The controller then runs one complete memory cycle: row strobe, column strobe, write enable, output enable and the multiplexed address pins. All strobe widths are counted in clocks set by parameters.

Three cycle kinds are supported. A read returns the addressed nibble with a single-cycle `rvalid_o` pulse. An early write lowers write enable before the column strobe falls, so the memory latches the data on that edge and its outputs stay off. A read-modify-write first reads with output enable low, then turns the bus around and merges the write data under the mask. It then lowers write enable while the column strobe is already low, so the memory latches the merged nibble on that edge.

The sequencer walks the states IDLE, ROW, COL, ACCESS, WRITE_STROBE and PRECHARGE. Its transitions are:
- IDLE to ROW when a request is accepted.
- ROW to COL after `1+T_RCD` clocks.
- COL to ACCESS after one clock.
- ACCESS to WRITE_STROBE for a read-modify-write, or ACCESS to PRECHARGE otherwise, after `T_CAS` clocks.
- WRITE_STROBE to PRECHARGE after `T_TURN+1+T_WP` clocks.
- PRECHARGE to IDLE after `T_PRE` clocks.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: The row half is `addr_i[15:8]` and the column half is `addr_i[7:0]`, both taken at acceptance. The row half is on `mem_addr_o` one clock before `mem_ras_n_o` falls and stays there while it falls. The column half is on `mem_addr_o` one clock before `mem_cas_n_o` falls and stays there while it falls.
- R2: `mem_ras_n_o` falls first and `mem_cas_n_o` falls afterwards. The column strobe is never low while the row strobe is high. Both strobes return high together on entry to PRECHARGE.
- R3: A request is accepted only in a clock where `req_i` is high and `busy_o` is low. `busy_o` is high from the clock after acceptance until the cycle ends. `req_i` is ignored while `busy_o` is high.
- R4: With defaults (T_RCD=2, T_CAS=2, T_TURN=1, T_WP=2, T_PRE=3), a read or a write keeps `busy_o` high for 9 clocks and a read-modify-write keeps it high for 13 clocks.
- R5: The command encoding of `cmd_i` is: 2'b00 read, 2'b01 early write, 2'b10 read-modify-write, 2'b11 handled as a read.
- R6: In a read, `mem_we_n_o` stays high and `mem_dq_oe_o` stays low. `mem_oe_n_o` is low for the T_CAS clocks of ACCESS. `mem_dq_i` is sampled at the last ACCESS clock and returned on `rdata_o` with `rvalid_o` high for exactly one clock, the first PRECHARGE clock. `wdata_i` has no effect on a read.
- R7: In an early write, `mem_we_n_o` is low and `mem_dq_o` carries the accepted data from the column setup clock to the end of ACCESS, which is 1+T_CAS clocks. Write enable is therefore low before the column strobe falls. `mem_oe_n_o` stays high and no `rvalid_o` pulse is produced.
- R8: In a read-modify-write, `mem_oe_n_o` is low during ACCESS. The old nibble is returned on `rdata_o` with a one-clock `rvalid_o` in the first WRITE_STROBE clock.
- R9: In WRITE_STROBE, `mem_oe_n_o` is high and the shared data lines are undriven for T_TURN clocks. The merged nibble is then driven one clock before `mem_we_n_o` falls, and write enable is low for T_WP clocks while the column strobe stays low. The merged nibble is `(old & ~wmask) | (wdata & wmask)`.
- R10: `mem_dq_oe_o` is high only while write data is driven, never while `mem_oe_n_o` is low, and never during a read.
- R11: PRECHARGE holds both strobes, write enable and output enable high for T_PRE clocks with the data lines undriven. Only then does IDLE accept a request.
- R12: During and after reset, all four strobes are high, `mem_dq_oe_o`, `busy_o` and `rvalid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Host request, taken when busy_o is low |
| cmd_i | input | 2 | Cycle kind (R5) |
| addr_i | input | 16 | Word address, row half in the upper byte |
| wdata_i | input | 4 | Write data |
| wmask_i | input | 4 | Read-modify-write merge mask, 1 takes the write bit |
| busy_o | output | 1 | A memory cycle is in progress |
| rvalid_o | output | 1 | One-clock pulse marking rdata_o valid |
| rdata_o | output | 4 | Captured read nibble |
| mem_addr_o | output | 8 | Multiplexed row/column address |
| mem_ras_n_o | output | 1 | Row strobe, active low |
| mem_cas_n_o | output | 1 | Column strobe, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 4 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o on the shared lines |
| mem_dq_i | input | 4 | Data from the memory |

## Verification
The bench attaches a behavioural memory that latches row and column on the strobe falling edges. It writes on the column edge when write enable is already low, and on the write-enable edge when the column strobe is low. It also flags any clock where both the memory and the controller drive the data lines. A controller that dropped write enable late would turn a write into a read-modify-write and miss its column-edge data. A controller that skipped the turnaround would show contention while the memory still drives. A wrong merge, or a mask applied in reverse, would show up when the address is read back later. Requests raised while busy, the reserved command code, and masks of all zeros and all ones are driven on purpose, because a design that got them wrong would corrupt unrelated addresses or miscount the busy window.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_ACCESS,
        ST_WSTRB,
        ST_PRECHG
    } cyc_state_t;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_RMW
    } op_kind_t;

    localparam logic [1:0] CMD_READ  = 2'b00;
    localparam logic [1:0] CMD_WRITE = 2'b01;
    localparam logic [1:0] CMD_RMW   = 2'b10;

    // Code 2'b11 falls back to a plain read.
    function automatic op_kind_t decode_cmd(input logic [1:0] code);
        op_kind_t k;
        case (code)
            CMD_WRITE: k = OP_WRITE;
            CMD_RMW:   k = OP_RMW;
            default:   k = OP_READ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_TURN = 1,
    parameter int T_WP   = 2,
    parameter int T_PRE  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [1:0] cmd_i,
    output logic       accept_o,
    output logic       busy_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o,
    output logic       oe_n_o,
    output logic       col_sel_o,
    output logic       drive_o,
    output logic       drive_mod_o,
    output logic       capture_o
);

    localparam int LEN_ROW = T_RCD + 1;
    localparam int LEN_ACC = T_CAS;
    localparam int LEN_WS  = T_TURN + 1 + T_WP;
    localparam int LEN_PRE = T_PRE;
    localparam int MAX_A   = (LEN_ROW > LEN_ACC) ? LEN_ROW : LEN_ACC;
    localparam int MAX_B   = (LEN_WS > LEN_PRE) ? LEN_WS : LEN_PRE;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_LEN + 1);

    localparam logic [CW-1:0] ROW_LAST = CW'(LEN_ROW - 1);
    localparam logic [CW-1:0] ACC_LAST = CW'(LEN_ACC - 1);
    localparam logic [CW-1:0] WS_LAST  = CW'(LEN_WS - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(LEN_PRE - 1);
    localparam logic [CW-1:0] WS_DRIVE = CW'(T_TURN);
    localparam logic [CW-1:0] WS_WE    = CW'(T_TURN + 1);

    cyc_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    op_kind_t      op_q, op_d;
    logic          accept;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_READ;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        op_d    = op_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (req_i) begin
                    accept  = 1'b1;
                    op_d    = decode_cmd(cmd_i);
                    state_d = ST_ROW;
                end
            end
            ST_ROW: begin
                if (cnt_q == ROW_LAST) begin
                    state_d = ST_COL;
                    cnt_d   = '0;
                end
            end
            ST_COL: begin
                state_d = ST_ACCESS;
                cnt_d   = '0;
            end
            ST_ACCESS: begin
                if (cnt_q == ACC_LAST) begin
                    state_d = (op_q == OP_RMW) ? ST_WSTRB : ST_PRECHG;
                    cnt_d   = '0;
                end
            end
            ST_WSTRB: begin
                if (cnt_q == WS_LAST) begin
                    state_d = ST_PRECHG;
                    cnt_d   = '0;
                end
            end
            ST_PRECHG: begin
                if (cnt_q == PRE_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        logic is_wr;
        logic ws_drive;
        logic ws_we;
        is_wr    = (op_q == OP_WRITE);
        ws_drive = (cnt_q >= WS_DRIVE);
        ws_we    = (cnt_q >= WS_WE);

        busy_o      = 1'b1;
        ras_n_o     = 1'b1;
        cas_n_o     = 1'b1;
        we_n_o      = 1'b1;
        oe_n_o      = 1'b1;
        col_sel_o   = 1'b1;
        drive_o     = 1'b0;
        drive_mod_o = 1'b0;
        capture_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                col_sel_o = 1'b0;
            end
            ST_ROW: begin
                col_sel_o = 1'b0;
                ras_n_o   = (cnt_q == '0);
            end
            ST_COL: begin
                ras_n_o = 1'b0;
                we_n_o  = !is_wr;
                drive_o = is_wr;
            end
            ST_ACCESS: begin
                ras_n_o   = 1'b0;
                cas_n_o   = 1'b0;
                we_n_o    = !is_wr;
                drive_o   = is_wr;
                oe_n_o    = is_wr;
                capture_o = !is_wr && (cnt_q == ACC_LAST);
            end
            ST_WSTRB: begin
                ras_n_o     = 1'b0;
                cas_n_o     = 1'b0;
                drive_o     = ws_drive;
                drive_mod_o = 1'b1;
                we_n_o      = !ws_we;
            end
            ST_PRECHG: begin
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign accept_o = accept;

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                col_sel_i,
    output logic [ADDR_W/2-1:0] mem_addr_o
);

    localparam int HALF = ADDR_W / 2;

    logic [HALF-1:0] row_q;
    logic [HALF-1:0] col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (load_i) begin
            row_q <= addr_i[ADDR_W-1:HALF];
            col_q <= addr_i[HALF-1:0];
        end
    end

    assign mem_addr_o = col_sel_i ? col_q : row_q;

endmodule

// File: rtl/dram_data_path.sv
module dram_data_path #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] wmask_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] mem_dq_i,
    input  logic              drive_mod_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] merged;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q  <= '0;
            mask_q   <= '0;
            rd_q     <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (load_i) begin
                wdata_q <= wdata_i;
                mask_q  <= wmask_i;
            end
            if (capture_i) begin
                rd_q <= mem_dq_i;
            end
            rvalid_q <= capture_i;
        end
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_merge
        assign merged[b] = mask_q[b] ? wdata_q[b] : rd_q[b];
    end

    assign dq_o     = drive_mod_i ? merged : wdata_q;
    assign rdata_o  = rd_q;
    assign rvalid_o = rvalid_q;

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 4,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_TURN = 1,
    parameter int T_WP   = 2,
    parameter int T_PRE  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [1:0]          cmd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [DATA_W-1:0]   wmask_i,
    output logic                busy_o,
    output logic                rvalid_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [ADDR_W/2-1:0] mem_addr_o,
    output logic                mem_ras_n_o,
    output logic                mem_cas_n_o,
    output logic                mem_we_n_o,
    output logic                mem_oe_n_o,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe_o,
    input  logic [DATA_W-1:0]   mem_dq_i
);

    localparam int MUX_W = ADDR_W / 2;

    logic accept;
    logic col_sel;
    logic drive;
    logic drive_mod;
    logic capture;

    dram_cycle_fsm #(
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_TURN(T_TURN),
        .T_WP  (T_WP),
        .T_PRE (T_PRE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .cmd_i      (cmd_i),
        .accept_o   (accept),
        .busy_o     (busy_o),
        .ras_n_o    (mem_ras_n_o),
        .cas_n_o    (mem_cas_n_o),
        .we_n_o     (mem_we_n_o),
        .oe_n_o     (mem_oe_n_o),
        .col_sel_o  (col_sel),
        .drive_o    (drive),
        .drive_mod_o(drive_mod),
        .capture_o  (capture)
    );

    dram_addr_mux #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .addr_i    (addr_i),
        .col_sel_i (col_sel),
        .mem_addr_o(mem_addr_o)
    );

    dram_data_path #(
        .DATA_W(DATA_W)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .wdata_i    (wdata_i),
        .wmask_i    (wmask_i),
        .capture_i  (capture),
        .mem_dq_i   (mem_dq_i),
        .drive_mod_i(drive_mod),
        .dq_o       (mem_dq_o),
        .rdata_o    (rdata_o),
        .rvalid_o   (rvalid_o)
    );

    assign mem_dq_oe_o = drive;

    logic [MUX_W-1:0] unused_width_probe;
    assign unused_width_probe = mem_addr_o;

endmodule

// File: rtl/dram_cycle_ctrl_sva.sv
module dram_cycle_ctrl_sva #(
    parameter int MUX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             rvalid_o,
    input logic [MUX_W-1:0] mem_addr_o,
    input logic             mem_ras_n_o,
    input logic             mem_cas_n_o,
    input logic             mem_we_n_o,
    input logic             mem_oe_n_o,
    input logic             mem_dq_oe_o
);

    a_r1_row_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n_o) |-> $stable(mem_addr_o));

    a_r1_col_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n_o) |-> $stable(mem_addr_o));

    a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n_o |-> !mem_ras_n_o);

    a_r2_strobes_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras_n_o) |-> mem_cas_n_o);

    a_r6_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o);

    a_r7_we_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_dq_oe_o);

    a_r9_data_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n_o) && !mem_cas_n_o) |-> ($past(mem_dq_oe_o) && mem_oe_n_o));

    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_ras_n_o && mem_cas_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

endmodule

bind dram_cycle_ctrl dram_cycle_ctrl_sva #(.MUX_W(MUX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .rvalid_o   (rvalid_o),
    .mem_addr_o (mem_addr_o),
    .mem_ras_n_o(mem_ras_n_o),
    .mem_cas_n_o(mem_cas_n_o),
    .mem_we_n_o (mem_we_n_o),
    .mem_oe_n_o (mem_oe_n_o),
    .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/dram_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_cycle_ctrl_tb_top;

    localparam int P_RCD  = 2;
    localparam int P_CAS  = 2;
    localparam int P_TURN = 1;
    localparam int P_WP   = 2;
    localparam int P_PRE  = 3;
    localparam int LEN_RW  = 1 + P_RCD + 1 + P_CAS + P_PRE;
    localparam int LEN_RMW = LEN_RW + P_TURN + 1 + P_WP;
    localparam int RV_POS  = 1 + P_RCD + 1 + P_CAS + 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [1:0]  cmd_i;
    logic [15:0] addr_i;
    logic [3:0]  wdata_i;
    logic [3:0]  wmask_i;
    logic        busy_o;
    logic        rvalid_o;
    logic [3:0]  rdata_o;
    logic [7:0]  mem_addr_o;
    logic        mem_ras_n_o;
    logic        mem_cas_n_o;
    logic        mem_we_n_o;
    logic        mem_oe_n_o;
    logic [3:0]  mem_dq_o;
    logic        mem_dq_oe_o;
    logic [3:0]  mem_dq_i;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dram_cycle_ctrl #(
        .T_RCD(P_RCD), .T_CAS(P_CAS), .T_TURN(P_TURN), .T_WP(P_WP), .T_PRE(P_PRE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cmd_i(cmd_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wmask_i(wmask_i), .busy_o(busy_o), .rvalid_o(rvalid_o),
        .rdata_o(rdata_o), .mem_addr_o(mem_addr_o), .mem_ras_n_o(mem_ras_n_o),
        .mem_cas_n_o(mem_cas_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] init_val(input logic [15:0] a);
        return a[3:0] ^ a[11:8] ^ a[15:12] ^ 4'h5;
    endfunction

    // Host-level reference contents and device contents
    logic [3:0] ref_mem [int];
    logic [3:0] dev_mem [int];

    function automatic logic [3:0] ref_rd(input logic [15:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return init_val(a);
    endfunction

    function automatic logic [3:0] dev_rd(input logic [15:0] a);
        if (dev_mem.exists(int'(a))) return dev_mem[int'(a)];
        return init_val(a);
    endfunction

    // Current operation, known to the device model
    logic [15:0] cur_addr;
    int          cur_kind;     // 0 read, 1 write, 2 rmw
    logic [3:0]  cur_exp_wr;

    // Behavioural memory on the multiplexed pins
    logic       ras_p, cas_p, we_p, dqoe_p;
    logic [7:0] addr_p;
    logic [7:0] dev_row;
    logic [3:0] dev_q;
    logic       dev_drive;

    assign dev_drive = !mem_ras_n_o && !mem_cas_n_o && !mem_oe_n_o && mem_we_n_o;
    assign mem_dq_i  = dev_drive ? dev_q : 4'h0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ras_p = 1'b1; cas_p = 1'b1; we_p = 1'b1; dqoe_p = 1'b0;
            addr_p = '0; dev_row = '0; dev_q = '0;
        end else begin
            if (ras_p && !mem_ras_n_o) begin
                dev_row = mem_addr_o;
                chk(mem_addr_o == cur_addr[15:8], "R1 row half at row strobe", 32'(mem_addr_o), 32'(cur_addr[15:8]));
                chk(addr_p == mem_addr_o, "R1 row half set up one clock early", 32'(addr_p), 32'(mem_addr_o));
            end
            if (!ras_p && mem_ras_n_o) begin
                chk(mem_cas_n_o, "R2 column strobe high at row strobe rise", 32'(mem_cas_n_o), 32'd1);
            end
            if (cas_p && !mem_cas_n_o) begin
                chk(!mem_ras_n_o, "R2 row strobe low before column strobe", 32'(mem_ras_n_o), 32'd0);
                chk(mem_addr_o == cur_addr[7:0], "R1 column half at column strobe", 32'(mem_addr_o), 32'(cur_addr[7:0]));
                chk(addr_p == mem_addr_o, "R1 column half set up one clock early", 32'(addr_p), 32'(mem_addr_o));
                if (!mem_we_n_o) begin
                    chk(cur_kind == 1, "R7 only early write has write enable low at column strobe", 32'(cur_kind), 32'd1);
                    chk(mem_dq_oe_o && mem_dq_o == cur_exp_wr, "R7 early write data at column strobe",
                        32'({mem_dq_oe_o, mem_dq_o}), 32'({1'b1, cur_exp_wr}));
                    dev_mem[int'({dev_row, mem_addr_o})] = mem_dq_o;
                end else begin
                    chk(cur_kind != 1, "R7 write enable low before column strobe", 32'(cur_kind), 32'd0);
                    dev_q = dev_rd({dev_row, mem_addr_o});
                end
            end
            if (we_p && !mem_we_n_o && !mem_cas_n_o) begin
                chk(cur_kind == 2, "R9 delayed write only in read-modify-write", 32'(cur_kind), 32'd2);
                chk(mem_oe_n_o, "R9 output enable high at write strobe", 32'(mem_oe_n_o), 32'd1);
                chk(dqoe_p, "R9 data driven one clock before write strobe", 32'(dqoe_p), 32'd1);
                chk(mem_dq_o == cur_exp_wr, "R9 merged data", 32'(mem_dq_o), 32'(cur_exp_wr));
                dev_mem[int'({dev_row, cur_addr[7:0]})] = mem_dq_o;
            end
            if (mem_dq_oe_o) begin
                chk(!dev_drive, "R10 no bus contention", 32'(dev_drive), 32'd0);
                chk(cur_kind != 0, "R10 R6 no data drive in read", 32'(cur_kind), 32'd1);
            end
            ras_p = mem_ras_n_o; cas_p = mem_cas_n_o; we_p = mem_we_n_o;
            dqoe_p = mem_dq_oe_o; addr_p = mem_addr_o;
        end
    end

    task automatic idle_quiet(input string tag);
        chk(mem_ras_n_o && mem_cas_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !busy_o && !rvalid_o,
            tag, 32'({mem_ras_n_o, mem_cas_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, busy_o, rvalid_o}),
            32'b1111000);
    endtask

    task automatic run_op(input logic [1:0] cmd, input logic [15:0] a, input logic [3:0] wd,
                          input logic [3:0] mk, input bit poke);
        int n, rv, rv_at, we_low, oe_low, quiet;
        int kind, exp_len, exp_we, exp_oe;
        logic [3:0] got, old;
        kind = (cmd == 2'b01) ? 1 : (cmd == 2'b10) ? 2 : 0;
        old  = ref_rd(a);
        @(negedge clk);
        chk(!busy_o, "R3 idle before request", 32'(busy_o), 32'd0);
        cur_addr   = a;
        cur_kind   = kind;
        cur_exp_wr = (kind == 2) ? ((old & ~mk) | (wd & mk)) : wd;
        req_i = 1'b1; cmd_i = cmd; addr_i = a; wdata_i = wd; wmask_i = mk;
        @(negedge clk);
        req_i = 1'b0;
        wdata_i = 4'($urandom); wmask_i = 4'($urandom); addr_i = 16'($urandom);
        n = 0; rv = 0; rv_at = 0; we_low = 0; oe_low = 0; quiet = 0; got = '0;
        while (busy_o && n < 100) begin
            n++;
            if (rvalid_o) begin rv++; rv_at = n; got = rdata_o; end
            if (!mem_we_n_o) we_low++;
            if (!mem_oe_n_o) oe_low++;
            if (mem_ras_n_o && mem_cas_n_o) quiet++;
            if (poke && n == 3) begin
                req_i = 1'b1; cmd_i = 2'b01; addr_i = ~a; wdata_i = ~wd;
            end else begin
                req_i = 1'b0;
            end
            @(negedge clk);
        end
        exp_len = (kind == 2) ? LEN_RMW : LEN_RW;
        exp_we  = (kind == 1) ? 1 + P_CAS : (kind == 2) ? P_WP : 0;
        exp_oe  = (kind == 1) ? 0 : P_CAS;
        chk(n == exp_len, "R4 R3 busy length", 32'(n), 32'(exp_len));
        chk(we_low == exp_we, "R7 R9 write enable low clocks", 32'(we_low), 32'(exp_we));
        chk(oe_low == exp_oe, "R6 R8 output enable low clocks", 32'(oe_low), 32'(exp_oe));
        chk(quiet == 1 + P_PRE, "R11 precharge length", 32'(quiet), 32'(1 + P_PRE));
        chk(rv == ((kind == 1) ? 0 : 1), "R6 R7 R8 rvalid pulse count", 32'(rv), 32'((kind == 1) ? 0 : 1));
        if (kind != 1) begin
            chk(rv_at == RV_POS, "R6 R8 rvalid position", 32'(rv_at), 32'(RV_POS));
            chk(got == old, "R6 R8 read data", 32'(got), 32'(old));
        end
        idle_quiet("R11 idle after cycle");
        if (kind == 1) ref_mem[int'(a)] = wd;
        if (kind == 2) ref_mem[int'(a)] = (old & ~mk) | (wd & mk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [7:0] rows [4];
        logic [7:0] cols [4];
        unused_seed = $urandom(32'h1D5A);
        rows = '{8'h00, 8'h3C, 8'hA5, 8'hFF};
        cols = '{8'h00, 8'h5A, 8'hC3, 8'hFF};
        rst_n = 1'b0; req_i = 1'b0; cmd_i = '0; addr_i = '0; wdata_i = '0; wmask_i = '0;
        cur_addr = '0; cur_kind = 0; cur_exp_wr = '0;
        repeat (3) @(negedge clk);
        idle_quiet("R12 outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_quiet("R12 outputs after reset");

        // Directed corners
        run_op(2'b00, 16'h0000, 4'hF, 4'h0, 1'b0);   // R6 untouched read returns initial contents
        run_op(2'b01, 16'h0000, 4'h9, 4'h0, 1'b0);   // R7 early write
        run_op(2'b00, 16'h0000, 4'h0, 4'hF, 1'b0);
        run_op(2'b01, 16'hFFFF, 4'h6, 4'h0, 1'b0);
        run_op(2'b11, 16'hFFFF, 4'h1, 4'h0, 1'b0);   // R5 reserved code reads
        run_op(2'b10, 16'h1234, 4'hA, 4'h5, 1'b0);   // R9 masked merge
        run_op(2'b10, 16'h1234, 4'h3, 4'h0, 1'b0);   // R9 mask zero keeps old data
        run_op(2'b10, 16'h1234, 4'hC, 4'hF, 1'b0);   // R9 mask all ones
        run_op(2'b00, 16'h1234, 4'h7, 4'h0, 1'b1);   // R3 request while busy ignored
        run_op(2'b00, 16'hEDCB, 4'h0, 4'h0, 1'b0);   // R3 poked address stays untouched
        run_op(2'b00, 16'h4242, 4'hB, 4'hF, 1'b0);   // R6 write data ignored on read
        run_op(2'b00, 16'h4242, 4'h0, 4'h0, 1'b0);

        for (int i = 0; i < 160; i++) begin
            logic [15:0] a;
            a = {rows[$urandom % 4], cols[$urandom % 4]};
            run_op(2'($urandom), a, 4'($urandom), 4'($urandom), ($urandom % 5) == 0);
        end

        // Final sweep of the address pool against the reference
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                run_op(2'b00, {rows[r], cols[c]}, 4'h0, 4'h0, 1'b0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule